// File: doc/BRIEF.md
# Single-Wire Bus Master Bit Engine

This block is the bit-level master for a single-wire, open-drain bus with a pull-up. It runs one of three operations each time it is started. The first is a bus reset that also detects whether a device is present. The second writes a stream of up to `DATA_W` bits. The third reads a stream of up to `DATA_W` bits. It never drives the wire high. It only turns on a pull-down through `line_oe` or lets the line float, and it reads the wire back through a synchronizer.

Slot timing is counted in microseconds. The number of clock cycles per microsecond is derived from the `CLK_HZ` parameter. A controller above this block sets up an operation, pulses `start`, waits for `done`, and then collects `presence` or `rd_data`. Command sequencing and device addressing belong to that controller.

Top module: `owm_bit_engine`

## Requirements
- R1: While `rst_n` is low, and after it is released, `busy`, `done`, `line_oe`, `presence` and `rd_data` are all 0.
- R2: A start with `op` = 2'b00 (bus reset) pulls the line low for exactly 480 µs, beginning in the cycle after `start` is accepted. It then releases the line for 480 µs (70 µs plus 410 µs), so the whole operation lasts 960 µs.
- R3: The synchronized line is sampled 70 µs after the reset pull-down ends. `presence` becomes 1 if the line is low at that point (a device answered) and 0 if it is high.
- R4: A start with `op` = 2'b01 writes bits of `wr_data`, least significant bit first. A 1 bit pulls the line low for 6 µs and then releases it for 64 µs. A 0 bit pulls it low for 60 µs and then releases it for 10 µs.
- R5: A start with `op` = 2'b10 runs read slots. Each slot pulls the line low for 6 µs, releases it, samples 9 µs later, and then waits 55 µs. The sample of slot i is stored in `rd_data[i]`. Bits at or above the slot count read as 0.
- R6: Write and read run min(`bit_cnt`, `DATA_W`) slots. A count of 0 runs no slot and raises `done` in the cycle after the start.
- R7: `done` is a single-cycle pulse. It appears in the first cycle after the last phase, which is the same cycle in which `busy` falls.
- R8: A `start` seen while `busy` is high is ignored. A start with `op` = 2'b11 is also ignored: `busy` stays low, no `done` is produced, and the line is not touched.
- R9: `line_oe` is high only while `busy` is high. A write or read leaves `presence` unchanged. A bus reset leaves `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, at frequency `CLK_HZ` |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts an operation when the block is idle |
| op | input | 2 | Operation: 00 reset, 01 write, 10 read, 11 none |
| wr_data | input | DATA_W | Bits to write, LSB first |
| bit_cnt | input | $clog2(DATA_W+1) | Number of slots for write or read |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when an operation ends |
| rd_data | output | DATA_W | Bits read, LSB first |
| presence | output | 1 | 1 when the last reset found a device |
| line_oe | output | 1 | 1 turns on the pull-down on the wire |
| line_in | input | 1 | Level sensed on the wire (asynchronous) |

## Verification
Let C be `CLK_HZ`/1e6. After the edge that accepts `start`, `line_oe` changes in the very next cycle. `busy` then stays high for exactly the sum of the phase lengths multiplied by C: 960·C for a reset and 70·C for each slot. `done` is high in the first cycle in which `busy` is low.

The bench samples on the falling clock edge. It counts the cycles in which `busy` is high and compares that count with the expected total. It measures every pull-down pulse in cycles and compares each one with the 480/60/6 µs values. It reads `presence` and `rd_data` in the cycle in which `done` is seen.

Sampling inside the block comes two synchronizer cycles after the line changes. For that reason the modelled device holds its response across a window that spans each sample point by many microseconds.

// File: rtl/owm_pkg.sv
package owm_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   typedef enum logic [1:0] {
      OP_RESET = 2'b00,
      OP_WRITE = 2'b01,
      OP_READ  = 2'b10,
      OP_NONE  = 2'b11
   } owm_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RST_LOW,
      ST_RST_WAIT,
      ST_RST_TAIL,
      ST_SLOT_LOW,
      ST_SLOT_REL,
      ST_SLOT_REC
   } owm_state_e;

   // phase lengths in microseconds
   localparam int unsigned US_RST_LOW   = 480;
   localparam int unsigned US_RST_SAMP  = 70;
   localparam int unsigned US_RST_TAIL  = 410;
   localparam int unsigned US_SHORT_LOW = 6;
   localparam int unsigned US_LONG_LOW  = 60;
   localparam int unsigned US_ONE_REL   = 64;
   localparam int unsigned US_ZERO_REL  = 10;
   localparam int unsigned US_RD_SAMP   = 9;
   localparam int unsigned US_RD_REC    = 55;
   localparam int unsigned US_MAX       = US_RST_LOW;
   localparam int unsigned US_W         = $clog2(US_MAX + 1);
endpackage

// File: rtl/owm_sync.sv
module owm_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   timeunit 1ns;
   timeprecision 1ps;

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else if (STAGES == 1) begin : g_one
         logic ff;
         always_ff @(posedge clk) begin
            if (!rst_n) ff <= 1'b1;
            else        ff <= d;
         end
         assign q = ff;
      end else begin : g_chain
         logic [STAGES-1:0] ff;
         always_ff @(posedge clk) begin
            if (!rst_n) ff <= '1;
            else        ff <= {ff[STAGES-2:0], d};
         end
         assign q = ff[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/owm_us_timer.sv
module owm_us_timer #(
   parameter int unsigned CYC_PER_US = 50,
   parameter int unsigned US_W       = 9,
   parameter int unsigned MAX_US     = 480
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [US_W-1:0] load_us,
   output logic            expire
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int unsigned TW = $clog2(MAX_US * CYC_PER_US + 1);

   logic [TW-1:0] cnt;

   // a phase loaded with N microseconds lasts exactly N*CYC_PER_US cycles
   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= TW'(32'(load_us) * CYC_PER_US - 32'd1);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign expire = (cnt == '0);
endmodule

// File: rtl/owm_bit_engine.sv
module owm_bit_engine
   import owm_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 50_000_000,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned CNT_W      = $clog2(DATA_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        op,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [CNT_W-1:0]  bit_cnt,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic              presence,
   output logic              line_oe,
   input  logic              line_in
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int unsigned CYC_PER_US = CLK_HZ / 1_000_000;

   if (CLK_HZ < 1_000_000 || (CLK_HZ % 1_000_000) != 0) begin : g_bad_clk
      $error("CLK_HZ must be a whole number of MHz");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be at least 1");
   end

   owm_state_e        state, state_d;
   logic [DATA_W-1:0] sh, sh_next;
   logic [CNT_W-1:0]  idx, last, n_eff;
   logic              is_read;
   logic              line_s;
   logic              tmr_load, tmr_exp;
   logic [US_W-1:0]   tmr_us;
   logic              finish, samp_rst, samp_rd, advance, end_slot, accept;
   logic              done_q, presence_q;
   logic [DATA_W-1:0] rd_q;

   owm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(line_in), .q(line_s)
   );

   owm_us_timer #(.CYC_PER_US(CYC_PER_US), .US_W(US_W), .MAX_US(US_MAX)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_us(tmr_us), .expire(tmr_exp)
   );

   assign n_eff   = (bit_cnt > CNT_W'(DATA_W)) ? CNT_W'(DATA_W) : bit_cnt;
   assign sh_next = sh >> 1;
   assign accept  = (state == ST_IDLE) && start
                    && ((owm_op_e'(op) == OP_WRITE) || (owm_op_e'(op) == OP_READ));

   always_comb begin
      state_d  = state;
      tmr_load = 1'b0;
      tmr_us   = '0;
      finish   = 1'b0;
      samp_rst = 1'b0;
      samp_rd  = 1'b0;
      advance  = 1'b0;
      end_slot = 1'b0;
      case (state)
         ST_IDLE: begin
            if (start) begin
               case (owm_op_e'(op))
                  OP_RESET: begin
                     state_d  = ST_RST_LOW;
                     tmr_load = 1'b1;
                     tmr_us   = US_W'(US_RST_LOW);
                  end
                  OP_WRITE, OP_READ: begin
                     if (n_eff == '0) begin
                        finish = 1'b1;
                     end else begin
                        state_d  = ST_SLOT_LOW;
                        tmr_load = 1'b1;
                        tmr_us   = (owm_op_e'(op) == OP_READ || wr_data[0])
                                   ? US_W'(US_SHORT_LOW) : US_W'(US_LONG_LOW);
                     end
                  end
                  default: ;
               endcase
            end
         end
         ST_RST_LOW: if (tmr_exp) begin
            state_d  = ST_RST_WAIT;
            tmr_load = 1'b1;
            tmr_us   = US_W'(US_RST_SAMP);
         end
         ST_RST_WAIT: if (tmr_exp) begin
            samp_rst = 1'b1;
            state_d  = ST_RST_TAIL;
            tmr_load = 1'b1;
            tmr_us   = US_W'(US_RST_TAIL);
         end
         ST_RST_TAIL: if (tmr_exp) begin
            state_d = ST_IDLE;
            finish  = 1'b1;
         end
         ST_SLOT_LOW: if (tmr_exp) begin
            state_d  = ST_SLOT_REL;
            tmr_load = 1'b1;
            tmr_us   = is_read ? US_W'(US_RD_SAMP)
                     : (sh[0] ? US_W'(US_ONE_REL) : US_W'(US_ZERO_REL));
         end
         ST_SLOT_REL: if (tmr_exp) begin
            if (is_read) begin
               samp_rd  = 1'b1;
               state_d  = ST_SLOT_REC;
               tmr_load = 1'b1;
               tmr_us   = US_W'(US_RD_REC);
            end else begin
               end_slot = 1'b1;
            end
         end
         ST_SLOT_REC: if (tmr_exp) end_slot = 1'b1;
         default: state_d = ST_IDLE;
      endcase

      if (end_slot) begin
         if (idx == last) begin
            state_d = ST_IDLE;
            finish  = 1'b1;
         end else begin
            state_d  = ST_SLOT_LOW;
            advance  = 1'b1;
            tmr_load = 1'b1;
            tmr_us   = (is_read || sh_next[0]) ? US_W'(US_SHORT_LOW) : US_W'(US_LONG_LOW);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         sh         <= '0;
         idx        <= '0;
         last       <= '0;
         is_read    <= 1'b0;
         done_q     <= 1'b0;
         presence_q <= 1'b0;
         rd_q       <= '0;
      end else begin
         state  <= state_d;
         done_q <= finish;
         if (accept || (state == ST_IDLE && start && owm_op_e'(op) == OP_READ)) begin
            sh      <= wr_data;
            idx     <= '0;
            last    <= n_eff - 1'b1;
            is_read <= (owm_op_e'(op) == OP_READ);
            if (owm_op_e'(op) == OP_READ) rd_q <= '0;
         end
         if (advance) begin
            sh  <= sh_next;
            idx <= idx + 1'b1;
         end
         if (samp_rst) presence_q <= ~line_s;
         if (samp_rd)  rd_q <= rd_q | (DATA_W'(line_s) << idx);
      end
   end

   assign busy     = (state != ST_IDLE);
   assign done     = done_q;
   assign rd_data  = rd_q;
   assign presence = presence_q;
   assign line_oe  = (state == ST_RST_LOW) || (state == ST_SLOT_LOW);
endmodule

// File: rtl/owm_bit_engine_chk.sv
module owm_bit_engine_chk #(
   parameter int unsigned DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [1:0]        op,
   input logic              busy,
   input logic              done,
   input logic [DATA_W-1:0] rd_data,
   input logic              presence,
   input logic              line_oe
);
   timeunit 1ns;
   timeprecision 1ps;

   // R9
   oe_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_oe |-> busy);

   // R7
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R8
   busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   // R8
   reserved_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && op == 2'b11) |=> (!busy && !done));

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(presence) && $stable(rd_data)));
endmodule

bind owm_bit_engine owm_bit_engine_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .op(op), .busy(busy), .done(done),
   .rd_data(rd_data), .presence(presence), .line_oe(line_oe)
);

// File: tb/owm_bit_engine_tb.sv
module owm_bit_engine_tb;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int unsigned CLK_HZ = 4_000_000;
   localparam int unsigned DATA_W = 16;
   localparam int unsigned CNT_W  = $clog2(DATA_W + 1);
   localparam int          CPU    = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [1:0]        op_i = 2'b00;
   logic [DATA_W-1:0] wr_data = '0;
   logic [CNT_W-1:0]  bit_cnt = '0;
   logic              busy, done, presence, line_oe, line_in;
   logic [DATA_W-1:0] rd_data;
   logic              pull = 1'b0;

   assign line_in = ~(line_oe | pull);

   owm_bit_engine #(.CLK_HZ(CLK_HZ), .DATA_W(DATA_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op_i), .wr_data(wr_data),
      .bit_cnt(bit_cnt), .busy(busy), .done(done), .rd_data(rd_data),
      .presence(presence), .line_oe(line_oe), .line_in(line_in)
   );

   always #2.5 clk = ~clk;

   int n_chk = 0, n_bad = 0;
   bit finished = 0;
   int widths[64];
   int nw = 0, run = 0, el = 0, slot_no = 0;
   bit prev_oe = 0;
   bit dev_present = 0, mode_reset = 0, mode_read = 0;
   logic [DATA_W-1:0] dev_bits = '0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // device model and pulse monitor, evaluated away from the active edge
   initial forever begin
      @(negedge clk);
      if (line_oe && !prev_oe) begin el = 0; slot_no++; end
      else el++;
      if (line_oe) run++;
      else if (prev_oe) begin
         if (nw < 64) widths[nw] = run;
         nw++;
         run = 0;
      end
      pull = (mode_reset && dev_present && el >= 500*CPU && el < 630*CPU)
          || (mode_read && slot_no > 0 && slot_no <= DATA_W
              && !dev_bits[slot_no-1] && el < 30*CPU);
      prev_oe = line_oe;
   end

   function automatic int eff_n(input int n);
      return (n > DATA_W) ? DATA_W : n;
   endfunction

   function automatic int exp_total(input int op, input int n);
      if (op == 0) return 960 * CPU;
      if (op == 3) return 0;
      return eff_n(n) * 70 * CPU;
   endfunction

   function automatic int exp_width(input int op, input bit b);
      if (op == 0) return 480 * CPU;
      if (op == 2) return 6 * CPU;
      return b ? 6 * CPU : 60 * CPU;
   endfunction

   function automatic logic [DATA_W-1:0] exp_rd(input logic [DATA_W-1:0] bits, input int n);
      logic [DATA_W-1:0] m = '0;
      for (int i = 0; i < eff_n(n); i++) m[i] = 1'b1;
      return bits & m;
   endfunction

   task automatic do_op(input int op, input logic [DATA_W-1:0] data, input int n,
                        input bit poke);
      int busy_cyc = 0;
      int nslots;
      bit wok = 1;
      logic [DATA_W-1:0] rd_before = rd_data;
      logic pres_before = presence;
      string req;
      req = (op == 0) ? "R2" : (op == 1) ? "R4" : (op == 2) ? "R5" : "R8";
      @(negedge clk);
      nw = 0; run = 0; slot_no = 0;
      mode_reset = (op == 0);
      mode_read  = (op == 2);
      op_i = 2'(op); wr_data = data; bit_cnt = CNT_W'(n);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (busy && busy_cyc < 20000) begin
         busy_cyc++;
         if (poke && busy_cyc == 50) begin start = 1'b1; op_i = 2'b00; end
         else start = 1'b0;
         @(negedge clk);
      end
      start = 1'b0;
      chk(busy_cyc == exp_total(op, n), req, "busy cycles", busy_cyc, exp_total(op, n));
      if (op == 3) chk(done == 1'b0, "R8", "done on reserved op", done, 0);
      else chk(done == 1'b1, "R7", "done after last phase", done, 1);
      nslots = (op == 0) ? 1 : (op == 3) ? 0 : eff_n(n);
      chk(nw == nslots, (n > DATA_W) ? "R6" : req, "pulse count", nw, nslots);
      for (int i = 0; i < nslots && i < nw; i++) begin
         if (widths[i] != exp_width(op, data[i]) && wok) begin
            wok = 0;
            chk(0, req, $sformatf("pulse %0d width", i), widths[i], exp_width(op, data[i]));
         end
      end
      if (wok && nslots > 0) chk(1, req, "pulse widths", 0, 0);
      if (op == 0) begin
         chk(presence == dev_present, "R3", "presence", presence, dev_present);
         chk(rd_data == rd_before, "R9", "rd_data held over reset", rd_data, rd_before);
      end else if (op == 2) begin
         chk(rd_data == exp_rd(dev_bits, n), "R5", "rd_data", rd_data, exp_rd(dev_bits, n));
         chk(presence == pres_before, "R9", "presence held over read", presence, pres_before);
      end else if (op == 1) begin
         chk(presence == pres_before, "R9", "presence held over write", presence, pres_before);
      end
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0, "R7", "done single pulse, no relaunch",
          {done, busy}, 0);
      mode_reset = 0; mode_read = 0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'h1e55);
      repeat (4) @(negedge clk);
      // R1 during and after reset
      chk({busy, done, line_oe, presence} == 4'b0 && rd_data == '0, "R1",
          "outputs in reset", {busy, done, line_oe, presence}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk({busy, done, line_oe, presence} == 4'b0 && rd_data == '0, "R1",
          "outputs after reset", {busy, done, line_oe, presence}, 0);

      // R2 R3 directed
      dev_present = 1; do_op(0, '0, 0, 0);
      dev_present = 0; do_op(0, '0, 0, 0);
      dev_present = 1; do_op(0, '0, 0, 0);
      // R4 directed
      do_op(1, 16'h0000, 8, 0);
      do_op(1, 16'hFFFF, 5, 0);
      do_op(1, 16'hA53C, 16, 0);
      // R6 clamp and zero count
      do_op(1, 16'h1234, 20, 0);
      do_op(1, 16'h00FF, 0, 0);
      // R5 directed
      dev_bits = 16'hFFFF; do_op(2, '0, 16, 0);
      dev_bits = 16'h0000; do_op(2, '0, 7, 0);
      dev_bits = 16'h5A96; do_op(2, '0, 12, 0);
      do_op(2, '0, 0, 0);
      // R8 reserved op and start while busy
      do_op(3, 16'hFFFF, 4, 0);
      do_op(1, 16'h0F0F, 6, 1);
      dev_bits = 16'hC3A5; do_op(2, '0, 9, 1);

      for (int k = 0; k < 24; k++) begin
         int o = $urandom % 4;
         logic [DATA_W-1:0] d = DATA_W'($urandom);
         int n = $urandom % (DATA_W + 4);
         dev_bits = DATA_W'($urandom);
         dev_present = $urandom % 2;
         do_op(o, d, n, ($urandom % 5) == 0);
      end

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule